// File: doc/BRIEF.md
# Banked Bit-Addressable Scratch RAM

This block is the 128-byte internal data store of a small 8-bit controller core. It carries out one operation per clock. The operation code selects the kind of access. Byte accesses can use a direct 7-bit address, the index of a working register, or a pointer held in a working register. The low 32 bytes hold four banks of eight working registers. Two bits of the program status byte, driven in on `psw_i`, pick the bank that register and pointer accesses see.

Bytes 20H to 2FH also form a flat space of 128 single bits. Bit operations read a byte, change one bit and write the byte back within the same cycle. Some bit operations combine the selected bit with an internal carry flag. An internal stack pointer supports push and pop into the same RAM. Read results, the carry flag and the stack pointer are registered outputs. Each one changes on the clock edge that ends the operation. Addresses at or above 80H belong to special function registers, which live elsewhere. This block treats accesses to that range as misses.

Top module: `iram_bank_top`

## Requirements
- R1: After reset, `rdata_q` is 00H, `carry_q` is 0, `sp_q` is 07H, and every RAM byte reads 00H.
- R2: Op 1 reads the byte at direct address `op_addr` onto `rdata_q` after the next edge. Op 2 writes `op_wdata` to that address. Neither op changes the carry flag or the stack pointer.
- R3: When a direct address has bit 7 set, op 2 writes nothing and op 1 returns 00H.
- R4: Register index n on `op_reg` with bank k = `psw_i[4:3]` maps to byte k*8+n. Op 3 reads that byte and op 4 writes it.
- R5: For op 5 (indirect read) and op 6 (indirect write), the pointer is register `op_reg[0]` (register 0 or 1) of the active bank. A pointer of 80H or above makes a read return 00H and makes a write do nothing.
- R6: Bit address b selects bit b[2:0] of byte 20H+b[6:3]. Op 7 sets that bit, op 8 clears it and op 9 complements it. No other bit changes. When b[7] is 1, the RAM is unchanged and the bit reads as 0.
- R7: Op 10 copies the selected bit into carry. Op 11 writes carry into the selected bit.
- R8: Op 12 ANDs carry with the selected bit, and op 13 ORs carry with it. When `op_inv` is 1, the complement of the bit is used instead.
- R9: Op 14 (push) increments `sp_q` and then writes `op_wdata` at the new pointer. Op 15 (pop) returns the byte at the old pointer and then decrements `sp_q`. A stack address of 80H or above is skipped on write and reads as 00H.
- R10: Op 0 changes nothing: the RAM, `rdata_q`, `carry_q` and `sp_q` all hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_code | input | 4 | Operation code, 0 to 15 |
| op_addr | input | 8 | Direct byte address or bit address |
| op_reg | input | 3 | Working register index |
| op_wdata | input | 8 | Write or push data |
| op_inv | input | 1 | Use the complement of the bit for AND/OR into carry |
| psw_i | input | 8 | Program status byte; bits 4:3 pick the bank |
| rdata_q | output | 8 | Registered read result |
| carry_q | output | 1 | Carry flag |
| sp_q | output | 8 | Stack pointer |

## Verification
The bench targets the places where address arithmetic can go wrong. One case is a register in bank 2 or 3 that lands at a wrong byte when the bank bits are dropped or shifted. Another is bit address 7FH, which a bad byte offset would move outside 2FH. A third is bit address 85H, which must not alias onto byte 20H. The bench also checks that a direct write to 85H leaves byte 05H untouched, and that an indirect access through a pointer of C0H is refused. A push that wrote before incrementing would leave stale data at 08H. A pop in the wrong order would return a neighbour byte. Running the complemented AND and OR with both carry values shows whether the inversion is applied.

// File: rtl/iram_pkg.sv
package iram_pkg;
    typedef enum logic [3:0] {
        OP_NOP  = 4'd0,
        OP_RDD  = 4'd1,
        OP_WRD  = 4'd2,
        OP_RDR  = 4'd3,
        OP_WRR  = 4'd4,
        OP_RDI  = 4'd5,
        OP_WRI  = 4'd6,
        OP_SETB = 4'd7,
        OP_CLRB = 4'd8,
        OP_CPLB = 4'd9,
        OP_B2C  = 4'd10,
        OP_C2B  = 4'd11,
        OP_ANLC = 4'd12,
        OP_ORLC = 4'd13,
        OP_PUSH = 4'd14,
        OP_POP  = 4'd15
    } iram_op_e;
endpackage

// File: rtl/iram_addr_map.sv
// Maps register indices through the bank and bit addresses onto the bit area.
module iram_addr_map #(
    parameter int DW        = 8,
    parameter int AW        = 7,
    parameter int BANK_BITS = 2,
    parameter int REG_BITS  = 3,
    parameter int BIT_BASE  = 32
) (
    input  logic [BANK_BITS-1:0] bank,
    input  logic [REG_BITS-1:0]  reg_idx,
    input  logic [DW-1:0]        bit_addr,
    output logic [AW-1:0]        reg_addr,
    output logic [AW-1:0]        bit_byte,
    output logic [$clog2(DW)-1:0] bit_pos,
    output logic                 bit_ok
);
    localparam int PW = $clog2(DW);

    assign reg_addr = AW'({bank, reg_idx});
    assign bit_byte = AW'(BIT_BASE) + AW'(bit_addr[DW-2:PW]);
    assign bit_pos  = bit_addr[PW-1:0];
    assign bit_ok   = ~bit_addr[DW-1];
endmodule

// File: rtl/iram_bit_alu.sv
// Read-modify-write of one bit and the carry combinations.
module iram_bit_alu import iram_pkg::*; #(
    parameter int DW = 8
) (
    input  iram_op_e              op,
    input  logic [DW-1:0]         byte_in,
    input  logic [$clog2(DW)-1:0] pos,
    input  logic                  bit_ok,
    input  logic                  carry_in,
    input  logic                  inv,
    output logic [DW-1:0]         byte_out,
    output logic                  byte_we,
    output logic                  carry_out
);
    localparam int PW = $clog2(DW);

    logic [DW-1:0] mask;
    logic          bit_val;
    logic          opnd;

    for (genvar i = 0; i < DW; i++) begin : g_mask
        assign mask[i] = (pos == PW'(i));
    end

    assign bit_val = bit_ok & ((byte_in & mask) != '0);
    assign opnd    = bit_val ^ inv;

    always_comb begin
        byte_out  = byte_in;
        byte_we   = 1'b0;
        carry_out = carry_in;
        case (op)
            OP_SETB: begin byte_out = byte_in | mask;  byte_we = bit_ok; end
            OP_CLRB: begin byte_out = byte_in & ~mask; byte_we = bit_ok; end
            OP_CPLB: begin byte_out = byte_in ^ mask;  byte_we = bit_ok; end
            OP_C2B: begin
                byte_out = carry_in ? (byte_in | mask) : (byte_in & ~mask);
                byte_we  = bit_ok;
            end
            OP_B2C:  carry_out = bit_val;
            OP_ANLC: carry_out = carry_in & opnd;
            OP_ORLC: carry_out = carry_in | opnd;
            default: ;
        endcase
    end
endmodule

// File: rtl/iram_bank_top.sv
module iram_bank_top import iram_pkg::*; #(
    parameter int DW        = 8,
    parameter int AW        = 7,
    parameter int BANK_BITS = 2,
    parameter int REG_BITS  = 3,
    parameter int BANK_LSB  = 3,
    parameter int BIT_BASE  = 32,
    parameter int SP_RST    = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [3:0]          op_code,
    input  logic [DW-1:0]       op_addr,
    input  logic [REG_BITS-1:0] op_reg,
    input  logic [DW-1:0]       op_wdata,
    input  logic                op_inv,
    input  logic [DW-1:0]       psw_i,
    output logic [DW-1:0]       rdata_q,
    output logic                carry_q,
    output logic [DW-1:0]       sp_q
);
    localparam int DEPTH = 1 << AW;
    localparam int PW    = $clog2(DW);

    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] mem;
        logic [DW-1:0]            sp;
        logic                     carry;
        logic [DW-1:0]            rdata;
    } iram_st_t;

    iram_st_t st_d, st_q;

    iram_op_e            op;
    logic                is_ind;
    logic [REG_BITS-1:0] reg_sel;
    logic [AW-1:0]       reg_addr, bit_byte;
    logic [PW-1:0]       bit_pos;
    logic                bit_ok;
    logic [DW-1:0]       reg_val, bit_in, bit_out;
    logic                bit_we, c_out;
    logic                dir_ok, ind_ok, up_ok, cur_ok;
    logic [DW-1:0]       sp_up, sp_dn;

    assign op      = iram_op_e'(op_code);
    assign is_ind  = (op == OP_RDI) || (op == OP_WRI);
    assign reg_sel = is_ind ? {{(REG_BITS-1){1'b0}}, op_reg[0]} : op_reg;

    iram_addr_map #(
        .DW(DW), .AW(AW), .BANK_BITS(BANK_BITS), .REG_BITS(REG_BITS), .BIT_BASE(BIT_BASE)
    ) u_map (
        .bank     (psw_i[BANK_LSB +: BANK_BITS]),
        .reg_idx  (reg_sel),
        .bit_addr (op_addr),
        .reg_addr (reg_addr),
        .bit_byte (bit_byte),
        .bit_pos  (bit_pos),
        .bit_ok   (bit_ok)
    );

    assign reg_val = st_q.mem[reg_addr];
    assign bit_in  = st_q.mem[bit_byte];
    assign dir_ok  = (op_addr[DW-1:AW] == '0);
    assign ind_ok  = (reg_val[DW-1:AW] == '0);
    assign sp_up   = st_q.sp + 1'b1;
    assign sp_dn   = st_q.sp - 1'b1;
    assign up_ok   = (sp_up[DW-1:AW] == '0);
    assign cur_ok  = (st_q.sp[DW-1:AW] == '0);

    iram_bit_alu #(.DW(DW)) u_alu (
        .op        (op),
        .byte_in   (bit_in),
        .pos       (bit_pos),
        .bit_ok    (bit_ok),
        .carry_in  (st_q.carry),
        .inv       (op_inv),
        .byte_out  (bit_out),
        .byte_we   (bit_we),
        .carry_out (c_out)
    );

    always_comb begin
        st_d = st_q;
        case (op)
            OP_RDD: st_d.rdata = dir_ok ? st_q.mem[op_addr[AW-1:0]] : '0;
            OP_WRD: if (dir_ok) st_d.mem[op_addr[AW-1:0]] = op_wdata;
            OP_RDR: st_d.rdata = reg_val;
            OP_WRR: st_d.mem[reg_addr] = op_wdata;
            OP_RDI: st_d.rdata = ind_ok ? st_q.mem[reg_val[AW-1:0]] : '0;
            OP_WRI: if (ind_ok) st_d.mem[reg_val[AW-1:0]] = op_wdata;
            OP_SETB, OP_CLRB, OP_CPLB, OP_C2B:
                if (bit_we) st_d.mem[bit_byte] = bit_out;
            OP_B2C, OP_ANLC, OP_ORLC: st_d.carry = c_out;
            OP_PUSH: begin
                st_d.sp = sp_up;
                if (up_ok) st_d.mem[sp_up[AW-1:0]] = op_wdata;
            end
            OP_POP: begin
                st_d.rdata = cur_ok ? st_q.mem[st_q.sp[AW-1:0]] : '0;
                st_d.sp    = sp_dn;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= '0;
            st_q.sp <= DW'(SP_RST);
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata_q = st_q.rdata;
    assign carry_q = st_q.carry;
    assign sp_q    = st_q.sp;
endmodule

// File: rtl/iram_bank_chk.sv
module iram_bank_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic [3:0]    op_code,
    input logic [DW-1:0] rdata_q,
    input logic          carry_q,
    input logic [DW-1:0] sp_q
);
    assert_push_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == 4'd14) |=> (sp_q == DW'($past(sp_q) + 1'b1)));

    assert_pop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == 4'd15) |=> (sp_q == DW'($past(sp_q) - 1'b1)));

    assert_nop_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == 4'd0) |=> ($stable(sp_q) && $stable(carry_q) && $stable(rdata_q)));

    assert_anl_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == 4'd12 && !carry_q) |=> !carry_q);

    assert_orl_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == 4'd13 && carry_q) |=> carry_q);

    assert_bitwr_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code inside {4'd7, 4'd8, 4'd9, 4'd11}) |=> ($stable(carry_q) && $stable(sp_q)));

    assert_byte_keep_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code inside {4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd6}) |=> ($stable(carry_q) && $stable(sp_q)));
endmodule

bind iram_bank_top iram_bank_chk #(.DW(DW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .op_code (op_code),
    .rdata_q (rdata_q),
    .carry_q (carry_q),
    .sp_q    (sp_q)
);

// File: tb/iram_bank_top_tb.sv
`timescale 1ns/1ps
module iram_bank_top_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] op_code = '0;
    logic [7:0] op_addr = '0;
    logic [2:0] op_reg = '0;
    logic [7:0] op_wdata = '0;
    logic       op_inv = 1'b0;
    logic [7:0] psw_i = '0;
    logic [7:0] rdata_q;
    logic       carry_q;
    logic [7:0] sp_q;

    int total = 0;
    int fails = 0;
    int m[128];
    int msp = 7;
    int mc = 0;
    int mrd = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    iram_bank_top u_dut (
        .clk(clk), .rst_n(rst_n), .op_code(op_code), .op_addr(op_addr),
        .op_reg(op_reg), .op_wdata(op_wdata), .op_inv(op_inv), .psw_i(psw_i),
        .rdata_q(rdata_q), .carry_q(carry_q), .sp_q(sp_q)
    );

    task automatic chk(string tag, string what, int act, int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic string tag_of(int op);
        case (op)
            0: return "R10";
            1, 2: return "R2";
            3, 4: return "R4";
            5, 6: return "R5";
            7, 8, 9: return "R6";
            10, 11: return "R7";
            12, 13: return "R8";
            default: return "R9";
        endcase
    endfunction

    // Behavioural reference: apply the op to the model, then compare after the edge.
    task automatic run(int op, int addr, int rg, int wd, int inv, int psw, string tag);
        int ra, p, by, bp, bv;
        bit ok;
        @(negedge clk);
        op_code = 4'(op); op_addr = 8'(addr); op_reg = 3'(rg);
        op_wdata = 8'(wd); op_inv = inv[0]; psw_i = 8'(psw);
        ra = ((psw >> 3) & 3) * 8 + (((op == 5) || (op == 6)) ? (rg & 1) : rg);
        ok = (addr < 128);
        by = 32 + ((addr & 127) >> 3);
        bp = addr & 7;
        bv = ok ? ((m[by] >> bp) & 1) : 0;
        case (op)
            1: mrd = ok ? m[addr] : 0;
            2: if (ok) m[addr] = wd;
            3: mrd = m[ra];
            4: m[ra] = wd;
            5: begin p = m[ra]; mrd = (p < 128) ? m[p] : 0; end
            6: begin p = m[ra]; if (p < 128) m[p] = wd; end
            7: if (ok) m[by] = m[by] | (1 << bp);
            8: if (ok) m[by] = m[by] & ~(1 << bp) & 255;
            9: if (ok) m[by] = m[by] ^ (1 << bp);
            10: mc = bv;
            11: if (ok) m[by] = mc ? (m[by] | (1 << bp)) : (m[by] & ~(1 << bp) & 255);
            12: mc = mc & (bv ^ inv);
            13: mc = mc | (bv ^ inv);
            14: begin msp = (msp + 1) & 255; if (msp < 128) m[msp] = wd; end
            15: begin mrd = (msp < 128) ? m[msp] : 0; msp = (msp - 1) & 255; end
            default: ;
        endcase
        @(posedge clk);
        #1;
        chk(tag, "rdata", int'(rdata_q), mrd);
        chk(tag, "carry", int'(carry_q), mc);
        chk(tag, "sp", int'(sp_q), msp);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", total - fails, total);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog: actual expired expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 128; i++) m[i] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1", "rdata", int'(rdata_q), 0);
        chk("R1", "carry", int'(carry_q), 0);
        chk("R1", "sp", int'(sp_q), 7);
        run(1, 8'h00, 0, 0, 0, 0, "R1");
        run(1, 8'h7F, 0, 0, 0, 0, "R1");
        // R2 direct
        run(2, 8'h30, 0, 8'hA5, 0, 0, "R2");
        run(1, 8'h30, 0, 0, 0, 0, "R2");
        // R3 out-of-range direct
        run(2, 8'h85, 0, 8'h3C, 0, 0, "R3");
        run(1, 8'h05, 0, 0, 0, 0, "R3");
        run(1, 8'h85, 0, 0, 0, 0, "R3");
        // R4 banked registers
        run(4, 0, 5, 8'h77, 0, 8'h10, "R4");
        run(1, 8'h15, 0, 0, 0, 0, "R4");
        run(4, 0, 7, 8'h99, 0, 8'h18, "R4");
        run(1, 8'h1F, 0, 0, 0, 0, "R4");
        run(3, 0, 5, 0, 0, 8'h10, "R4");
        // R5 indirect through bank 1
        run(4, 0, 1, 8'h40, 0, 8'h08, "R5");
        run(6, 0, 1, 8'h9E, 0, 8'h08, "R5");
        run(1, 8'h40, 0, 0, 0, 0, "R5");
        run(4, 0, 0, 8'hC0, 0, 8'h08, "R5");
        run(5, 0, 0, 0, 0, 8'h08, "R5");
        run(5, 0, 1, 0, 0, 8'h08, "R5");
        // R6 bit ops
        run(7, 8'h7F, 0, 0, 0, 0, "R6");
        run(1, 8'h2F, 0, 0, 0, 0, "R6");
        run(9, 8'h00, 0, 0, 0, 0, "R6");
        run(1, 8'h20, 0, 0, 0, 0, "R6");
        run(8, 8'h7F, 0, 0, 0, 0, "R6");
        run(1, 8'h2F, 0, 0, 0, 0, "R6");
        run(7, 8'h85, 0, 0, 0, 0, "R6");
        run(1, 8'h20, 0, 0, 0, 0, "R6");
        // R7 copy bit <-> carry
        run(10, 8'h00, 0, 0, 0, 0, "R7");
        run(11, 8'h13, 0, 0, 0, 0, "R7");
        run(1, 8'h22, 0, 0, 0, 0, "R7");
        // R8 AND/OR with optional complement
        run(12, 8'h01, 0, 0, 1, 0, "R8");
        run(12, 8'h01, 0, 0, 0, 0, "R8");
        run(13, 8'h01, 0, 0, 1, 0, "R8");
        run(12, 8'h00, 0, 0, 1, 0, "R8");
        run(13, 8'h00, 0, 0, 0, 0, "R8");
        // R9 stack
        run(14, 0, 0, 8'h5A, 0, 0, "R9");
        run(14, 0, 0, 8'h6B, 0, 0, "R9");
        run(15, 0, 0, 0, 0, 0, "R9");
        run(15, 0, 0, 0, 0, 0, "R9");
        run(1, 8'h08, 0, 0, 0, 0, "R9");
        // R10 no-op hold
        run(0, 8'h08, 3, 8'hFF, 1, 8'h18, "R10");
        // random mix
        for (int i = 0; i < 3000; i++) begin
            int op, addr;
            op = $urandom_range(0, 15);
            addr = ($urandom_range(0, 3) == 0) ? $urandom_range(0, 255) : $urandom_range(0, 127);
            run(op, addr, $urandom_range(0, 7), $urandom_range(0, 255),
                $urandom_range(0, 1), $urandom_range(0, 255), tag_of(op));
        end
        // full sweep of the RAM against the model
        for (int a = 0; a < 128; a++) run(1, a, 0, 0, 0, 0, "R2");
        done = 1;
        summary();
        $finish;
    end
endmodule